// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit. It is assembled from one-bit slices that are chained through a ripple carry. It accepts two operands and a three-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a signed overflow flag. The supported functions are bitwise AND, bitwise OR, addition, subtraction and signed set-less-than.

The top bit of the operation code is a negate line. It inverts the B operand in every slice and also feeds the carry into bit 0, so subtraction is performed as a + ~b + 1. For set-less-than, the sign of that difference is taken from the most significant position and corrected for overflow. The corrected value is routed to the less input of bit 0, and the less input of every other slice is tied low. A datapath uses the zero flag after a subtraction to test two operands for equality.

Top module: `ripple_alu`

## Requirements
- R1: Operation code 3'b000 drives result_o with a_i AND b_i.
- R2: Operation code 3'b001 drives result_o with a_i OR b_i.
- R3: Operation code 3'b010 drives result_o with (a_i + b_i) modulo 2^WIDTH.
- R4: Operation code 3'b110 drives result_o with (a_i - b_i) modulo 2^WIDTH, formed as a_i + ~b_i + 1.
- R5: Operation code 3'b111 drives result_o bit 0 high exactly when a_i is less than b_i as two's complement numbers, including operand pairs whose difference overflows. All higher bits of result_o are zero.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every operation code. In particular, subtracting equal operands raises it.
- R7: For operation code 3'b010, ovf_o is 1 exactly when both operands have the same sign and the sum has the opposite sign.
- R8: For operation code 3'b110, ovf_o is 1 exactly when the operands differ in sign and the sign of the difference differs from the sign of a_i.
- R9: ovf_o is 0 for every operation code other than 3'b010 and 3'b110.
- R10: The unused operation codes 3'b011, 3'b100 and 3'b101 drive result_o to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code; bit 2 negates B and sets the carry-in |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
The bench builds two instances. The first has WIDTH = 4 and is driven with every operand pair under all eight operation codes. This reaches every signed-overflow combination, every compare whose internal difference wraps, and each unused code. The second instance uses the default WIDTH = 32 and checks the extreme values 0x80000000 and 0x7FFFFFFF, equal operands, and a batch of random operands. This confirms that the carry ripples correctly over the full word and that the corrected sign reaches bit 0.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic op_is_valid(input logic [2:0] op);
    return (op == ALU_AND) || (op == ALU_OR) || (op == ALU_ADD) ||
           (op == ALU_SUB) || (op == ALU_SLT);
  endfunction

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == ALU_ADD) || (op == ALU_SUB);
  endfunction
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o
);
  logic b_eff;
  logic sum;

  assign b_eff  = b_i ^ binv_i;
  assign sum    = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic binv_i,
  input  logic cin_i,
  input  logic cout_i,
  output logic set_o,
  output logic ovf_o
);
  logic sum_msb;

  assign sum_msb = a_msb_i ^ b_msb_i ^ binv_i ^ cin_i;
  // carry into vs. carry out of the sign position
  assign ovf_o   = cin_i ^ cout_i;
  // sign of a - b, corrected when the difference wraps
  assign set_o   = sum_msb ^ ovf_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             negate_b;
  slice_sel_e       sel;
  logic             carry [WIDTH+1];
  logic             less_w [WIDTH];
  logic [WIDTH-1:0] slice_res;
  logic             set_w;
  logic             ovf_raw;

  assign negate_b = op_i[2];
  assign sel      = slice_sel_e'(op_i[1:0]);
  assign carry[0] = negate_b;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    if (g == 0) begin : g_lsb
      assign less_w[g] = set_w;
    end else begin : g_hi
      assign less_w[g] = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_i    (a_i[g]),
      .b_i    (b_i[g]),
      .binv_i (negate_b),
      .cin_i  (carry[g]),
      .less_i (less_w[g]),
      .sel_i  (sel),
      .res_o  (slice_res[g]),
      .cout_o (carry[g+1])
    );
  end

  alu_sign_unit u_sign (
    .a_msb_i (a_i[MSB]),
    .b_msb_i (b_i[MSB]),
    .binv_i  (negate_b),
    .cin_i   (carry[MSB]),
    .cout_i  (carry[WIDTH]),
    .set_o   (set_w),
    .ovf_o   (ovf_raw)
  );

  assign result_o = op_is_valid(op_i) ? slice_res : '0;
  assign ovf_o    = op_is_arith(op_i) & ovf_raw;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .val_i  (result_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      // R5
      slt_upper_clear_chk: assert (op_i != ALU_SLT || result_o[MSB:1] == '0);
      // R7
      add_ovf_chk: assert (!(op_i == ALU_ADD && a_i[MSB] == b_i[MSB] &&
                             result_o[MSB] != a_i[MSB]) || ovf_o);
      // R8
      sub_ovf_chk: assert (!(op_i == ALU_SUB && a_i[MSB] != b_i[MSB] &&
                             result_o[MSB] != a_i[MSB]) || ovf_o);
      // R9
      no_overflow_chk: assert (op_i == ALU_ADD || op_i == ALU_SUB || !ovf_o);
      // R6
      equal_zero_chk: assert (!(op_i == ALU_SUB && a_i == b_i) || zero_o);
      // R10
      unused_code_chk: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) ||
                               (result_o == '0 && zero_o));
    end
  end
endmodule

// File: tb/tb_ripple_alu.sv
module tb_ripple_alu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] a32 = '0, b32 = '0, res32;
  logic [2:0]  op32 = 3'b000;
  logic        z32, v32;
  logic [3:0]  a4 = '0, b4 = '0, res4;
  logic [2:0]  op4 = 3'b000;
  logic        z4, v4;

  ripple_alu #(.WIDTH(32)) dut (
    .a_i(a32), .b_i(b32), .op_i(op32), .result_o(res32), .zero_o(z32), .ovf_o(v32)
  );
  ripple_alu #(.WIDTH(4)) dut_nib (
    .a_i(a4), .b_i(b4), .op_i(op4), .result_o(res4), .zero_o(z4), .ovf_o(v4)
  );

  function automatic void model(input int w, input longint unsigned a, input longint unsigned b,
                                input logic [2:0] op, output longint unsigned r,
                                output bit z, output bit v);
    longint unsigned m = (64'd1 << w) - 1;
    longint sa, sb, t;
    longint lo = -(longint'(1) << (w - 1));
    longint hi = (longint'(1) << (w - 1)) - 1;
    sa = a[w-1] ? longint'(a) - longint'(64'd1 << w) : longint'(a);
    sb = b[w-1] ? longint'(b) - longint'(64'd1 << w) : longint'(b);
    v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin r = (a + b) & m; t = sa + sb; v = (t < lo) || (t > hi); end
      3'b110: begin r = (a - b) & m; t = sa - sb; v = (t < lo) || (t > hi); end
      3'b111: r = (sa < sb) ? 64'd1 : 64'd0;
      default: r = 64'd0;
    endcase
    z = (r == 0);
  endfunction

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [2:0] op);
    case (op)
      3'b010: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input int w, input logic [2:0] op, input longint unsigned ar,
                         input bit az, input bit av, input longint unsigned a,
                         input longint unsigned b);
    longint unsigned er;
    bit ez, ev;
    model(w, a, b, op, er, ez, ev);
    vectors++;
    if (ar != er) begin
      miscompares++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h result actual=%h expected=%h",
               res_tag(op), w, op, a, b, ar, er);
    end
    if (az != ez) begin
      miscompares++;
      $display("FAIL R6 w=%0d op=%b a=%h b=%h zero actual=%0b expected=%0b",
               w, op, a, b, az, ez);
    end
    if (av != ev) begin
      miscompares++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h ovf actual=%0b expected=%0b",
               ovf_tag(op), w, op, a, b, av, ev);
    end
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op32 = op; a32 = a; b32 = b;
    #5;
    compare(32, op, longint'(res32), z32, v32, longint'(a), longint'(b));
  endtask

  task automatic run4(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    op4 = op; a4 = a; b4 = b;
    #5;
    compare(4, op, longint'(res4), z4, v4, longint'(a), longint'(b));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // idle state: AND of zeros, zero flag high (R1, R6)
    run32(3'b000, 32'h0, 32'h0);

    // exhaustive 4-bit sweep: R1..R10
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(3'(op), 4'(a), 4'(b));

    // 32-bit corners
    run32(3'b000, 32'hF0F0_A5A5, 32'h0FF0_FFFF);   // R1
    run32(3'b001, 32'hF000_0001, 32'h0000_FF00);   // R2
    run32(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);   // R3 R7 positive wrap
    run32(3'b010, 32'h8000_0000, 32'h8000_0000);   // R7 negative wrap, R6 zero
    run32(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);   // R3 carry out, no ovf, R6
    run32(3'b110, 32'h8000_0000, 32'h0000_0001);   // R4 R8
    run32(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R8
    run32(3'b110, 32'h1234_5678, 32'h1234_5678);   // R6 equality
    run32(3'b111, 32'h8000_0000, 32'h0000_0001);   // R5 wrapped difference
    run32(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);   // R5 wrapped difference
    run32(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);   // R5
    run32(3'b111, 32'h0000_0005, 32'h0000_0005);   // R5 equal
    run32(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R10 R9
    run32(3'b100, 32'hFFFF_FFFF, 32'h0000_0001);   // R10
    run32(3'b101, 32'h8000_0000, 32'h8000_0000);   // R10 R9

    // random 32-bit operands on every code
    for (int i = 0; i < 600; i++)
      run32(3'(i % 8), $urandom(), $urandom());

    finish_run();
  end
endmodule